// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital heart of a successive-approximation analog-to-digital converter. A conversion is requested on a bus-style interface. The block then walks a trial word through its bits, from the most significant bit down. It sends each trial word to an external capacitive DAC and reads back one comparator decision per bit. When the walk ends, it places the finished code in an output register that a processor reads over a three-state data bus.

A processor selects the block with an active-low chip select. It requests a conversion by driving the active-low start line from high to low, and it reads with an active-low read strobe. The busy flag is low while a conversion runs, and its rising edge marks fresh data. The result register is separate from the approximation register. The last finished code therefore stays readable for the whole of the next conversion and is replaced just before busy rises, so a result is never delayed to a later conversion. Start requests made while a conversion is running are discarded.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion begins only when the clock samples `convst_n` low after having sampled it high on the previous clock, and `cs_n` is low in that same sample. A falling edge with `cs_n` high starts nothing. A level that stays low starts nothing. A rising edge starts nothing.
- R2: On the clock that accepts a start, the approximation register is cleared to zero, so `dac_word` reads 0, and `busy` goes low.
- R3: Bits are resolved from bit NBITS-1 down to bit 0. Each bit is first set to 1 for one clock with all lower bits 0. On the next clock it stays 1 if `cmp_hi` is 1 and is cleared if `cmp_hi` is 0. Higher bits that are already resolved do not change.
- R4: While `busy` is low, any falling edge of `convst_n` is ignored, and the running conversion finishes with unchanged timing and result.
- R5: `busy` stays low for exactly 2*NBITS+2 clocks (26 for 12 bits). The new code is in the output register one clock before `busy` rises.
- R6: Until that load, the output register keeps the previous result, so a read during a conversion returns the previous code.
- R7: `data_oe` is 1 exactly when `cs_n` and `rd_n` are both low. `data_bus` then carries the output register; otherwise `data_bus` is high-impedance.
- R8: The result is two's complement: the lowest input gives 12'h800 and the highest gives 12'h7FF. `dac_word` is offset binary, which is the code with its MSB inverted. After a conversion, `dac_word` holds the final word. With `cmp_hi` = 1 whenever (input code with its MSB inverted) >= `dac_word`, the result equals the input code.
- R9: After reset, `busy` is 1, the output register is 0 and `dac_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bit-step clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select for start and read |
| convst_n | input | 1 | Active-low conversion start, acts on its falling edge |
| rd_n | input | 1 | Active-low read strobe |
| cmp_hi | input | 1 | Comparator decision: held input is at or above the trial word |
| dac_word | output | NBITS | Offset-binary trial word to the DAC |
| busy | output | 1 | Low while a conversion runs |
| data_oe | output | 1 | High while the data drivers are enabled |
| data_bus | output | NBITS | Three-state two's-complement result |

## Verification
On every cycle, the embedded assertions check several properties. A start clears the register and drops busy. Each bit is trialled with the bits below it zero and is then decided by the comparator. Already resolved upper bits never move. Busy only falls out of the idle state. The output register is steady while busy is low except at the load, and busy rises exactly two clocks after the load. Only the bench's scenarios can show the rest: the full transfer function over every input code, including both extreme codes; the exact busy width; stale data during a conversion; chip-select gating of start edges; and the bus enable for each combination of select and read.

// File: rtl/sar_ctrl_pkg.sv
// Package: shared state encoding for the conversion sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package sar_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for an accepted start
        ST_SET,      // trial bit about to be set
        ST_DECIDE,   // comparator decision applied to the trial bit
        ST_LOAD,     // final word copied into the output register
        ST_RELEASE   // busy returns high
    } sar_state_e;

endpackage

// File: rtl/sar_start_detect.sv
// Start detector: turns a falling edge of the conversion start line into a
// one-clock request, gated by chip select at the clock that sees the edge.
// Assumes convst_n and cs_n are already synchronous to clk.
module sar_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic convst_n,
    output logic start_req
);

    logic conv_prev_q;

    // Remember the start line from the previous clock (idle level is high).
    always_ff @(posedge clk) begin
        if (!rst_n) conv_prev_q <= 1'b1;
        else        conv_prev_q <= convst_n;
    end

    // Falling edge seen while the block is selected.
    assign start_req = conv_prev_q & ~convst_n & ~cs_n;

endmodule

// File: rtl/sar_seq.sv
// Approximation sequencer: owns the approximation register and the bit
// pointer, walks MSB to LSB with two clocks per bit, and drives busy.
// Assumes cmp_hi is valid one clock after the trial word changes.
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] trial,
    output logic             busy,
    output logic             load,
    output logic [NBITS-1:0] code
);

    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NBITS - 1);

    sar_state_e       st_q;
    logic [IDX_W-1:0] idx_q;
    logic [NBITS-1:0] sar_q;
    logic             busy_q;
    logic [NBITS-1:0] low_mask;
    logic [NBITS-1:0] hi_mask;
    logic [NBITS-1:0] cur_mask;

    // Sequencer state, bit pointer, approximation register and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            sar_q  <= '0;
            busy_q <= 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_req) begin
                        sar_q  <= '0;
                        idx_q  <= TOP_IDX;
                        busy_q <= 1'b0;
                        st_q   <= ST_SET;
                    end
                end
                ST_SET: begin
                    sar_q[idx_q] <= 1'b1;
                    st_q         <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (!cmp_hi) sar_q[idx_q] <= 1'b0;
                    if (idx_q == '0) begin
                        st_q <= ST_LOAD;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                        st_q  <= ST_SET;
                    end
                end
                ST_LOAD: begin
                    st_q <= ST_RELEASE;
                end
                ST_RELEASE: begin
                    busy_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Bit masks around the current pointer, used by the checks below.
    always_comb begin
        cur_mask = NBITS'(1) << idx_q;
        low_mask = cur_mask - NBITS'(1);
        hi_mask  = ~((NBITS'(2) << idx_q) - NBITS'(1));
    end

    // Outputs: offset-binary trial word and its two's-complement reading.
    assign trial = sar_q;
    assign busy  = busy_q;
    assign load  = (st_q == ST_LOAD);
    assign code  = {~sar_q[NBITS-1], sar_q[NBITS-2:0]};

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_req) |=> (sar_q == '0 && !busy_q)); // R2

    AST_TRIAL_BELOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |-> ((sar_q & low_mask) == '0 && (sar_q & cur_mask) != '0)); // R3

    AST_UPPER_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |=> ((sar_q & $past(hi_mask)) == ($past(sar_q) & $past(hi_mask)))); // R3

    AST_DECISION_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |=> (((sar_q & $past(cur_mask)) != '0) == $past(cmp_hi))); // R3

    AST_BUSY_FALLS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(st_q) == ST_IDLE)); // R4

endmodule

// File: rtl/sar_out_latch.sv
// Output register and bus drivers: captures the finished code on load and
// drives it onto the three-state bus while selected and read.
// Assumes load is a single-clock pulse from the sequencer.
module sar_out_latch #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] code,
    input  logic             cs_n,
    input  logic             rd_n,
    output logic [NBITS-1:0] held,
    output logic             data_oe,
    output logic [NBITS-1:0] data_bus
);

    logic [NBITS-1:0] held_q;

    // Keep the last finished code until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= code;
    end

    // Drivers on only while both select and read are asserted.
    assign data_oe  = ~cs_n & ~rd_n;
    assign data_bus = data_oe ? held_q : {NBITS{1'bz}};
    assign held     = held_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
// Top level of the conversion control core: start detection, bit sequencing
// and the result register with its bus drivers.
// Assumes all inputs are synchronous to clk; the analog parts are external.
module sar_conv_ctrl #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             convst_n,
    input  logic             rd_n,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] dac_word,
    output logic             busy,
    output logic             data_oe,
    output logic [NBITS-1:0] data_bus
);

    logic             start_req;
    logic             load;
    logic [NBITS-1:0] code;
    logic [NBITS-1:0] held;

    sar_start_detect u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .convst_n  (convst_n),
        .start_req (start_req)
    );

    sar_seq #(.NBITS(NBITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .cmp_hi    (cmp_hi),
        .trial     (dac_word),
        .busy      (busy),
        .load      (load),
        .code      (code)
    );

    sar_out_latch #(.NBITS(NBITS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .code     (code),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .held     (held),
        .data_oe  (data_oe),
        .data_bus (data_bus)
    );

    AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(held)); // R6

    AST_LOAD_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load, 2)); // R5

endmodule

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
// Bench: comparator modelled on a stored two's-complement code; sweeps all
// 4096 codes and exercises start gating, restart rejection and bus enable.
module sar_conv_ctrl_test;

    localparam int NB    = 12;
    localparam int BUSYW = 2 * NB + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b0;
    logic          convst_n = 1'b1;
    logic          rd_n = 1'b0;
    logic [NB-1:0] x_code = '0;
    logic          cmp_hi;
    logic [NB-1:0] dac_word;
    logic          busy;
    logic          data_oe;
    wire  [NB-1:0] data_bus;

    int total = 0;
    int bad   = 0;
    logic [NB-1:0] last_code = '0;

    always #10 clk = ~clk;

    // Comparator model: offset form of the held input against the trial word.
    assign cmp_hi = ({~x_code[NB-1], x_code[NB-2:0]} >= dac_word);

    sar_conv_ctrl #(.NBITS(NB)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .convst_n (convst_n),
        .rd_n     (rd_n),
        .cmp_hi   (cmp_hi),
        .dac_word (dac_word),
        .busy     (busy),
        .data_oe  (data_oe),
        .data_bus (data_bus)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One conversion with cs_n and rd_n low; optional restart poke mid-way.
    task automatic convert(input logic [NB-1:0] val, input bit poke);
        int  n;
        bit  stale_ok;
        bit  new_ok;
        x_code = val;
        @(negedge clk); convst_n = 1'b0;
        @(negedge clk); convst_n = 1'b1;
        check(busy === 1'b0, "R1 start accepted", busy, 0);
        check(dac_word == '0, "R2 register cleared", dac_word, 0);
        n = 0; stale_ok = 1'b1; new_ok = 1'b0;
        while (busy === 1'b0 && n < 100) begin
            if (n < BUSYW - 1) stale_ok &= (data_bus === last_code);
            else if (n == BUSYW - 1) new_ok = (data_bus === val);
            if (poke && n == 4) convst_n = 1'b0;
            if (poke && n == 5) convst_n = 1'b1;
            n++;
            @(negedge clk);
        end
        check(n == BUSYW, poke ? "R4 busy width with restart" : "R5 busy width", n, BUSYW);
        check(stale_ok, "R6 previous result during conversion", data_bus, last_code);
        check(new_ok, "R5 new code one clock before busy", data_bus, val);
        check(data_bus === val, "R8 result code", data_bus, val);
        check(dac_word == (val ^ 12'h800), "R8 offset trial word", dac_word, val ^ 12'h800);
        last_code = val;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(busy === 1'b1, "R9 busy after reset", busy, 1);
        check(data_bus === '0, "R9 result after reset", data_bus, 0);
        check(dac_word == '0, "R9 trial after reset", dac_word, 0);

        // R8 extremes, then R3 decision path via a mid-scale pattern
        convert(12'h7FF, 1'b0);
        convert(12'h800, 1'b0);
        convert(12'h555, 1'b0);
        convert(12'hAAA, 1'b0);

        // R4 restart attempt during a conversion
        convert(12'h123, 1'b1);

        // R1 edge with chip select high starts nothing
        x_code = 12'h3C3;
        cs_n = 1'b1;
        @(negedge clk); convst_n = 1'b0;
        @(negedge clk); convst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(busy === 1'b1, "R1 no start with cs_n high", busy, 1);
        // R1 select while the line is already low: no edge, no start
        convst_n = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check(busy === 1'b1, "R1 level low gives no start", busy, 1);
        // R1 rising edge gives no start
        convst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(busy === 1'b1, "R1 rising edge gives no start", busy, 1);
        check(data_bus === last_code, "R1 result unchanged", data_bus, last_code);

        // R7 bus enable over select/read combinations
        for (int k = 0; k < 4; k++) begin
            cs_n = k[0]; rd_n = k[1];
            #1;
            check(data_oe === (k == 0), "R7 data_oe", data_oe, (k == 0));
        end
        cs_n = 1'b0; rd_n = 1'b0; #1;
        check(data_bus === last_code, "R7 bus carries result", data_bus, last_code);

        // R8 exhaustive sweep of all input codes
        for (int v = 0; v < 4096; v++) convert(NB'(v), 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule